// File: doc/BRIEF.md
# Keyed Write-Enable Unlock Sequencer

This block holds the write-enable level that must be high before any protected timer register may be written. Setting that level is guarded. A bus master first writes a two-byte key, 0x55 and then 0xAA, to a dedicated key register. It then has to request the set through the control register within a short window that opens in the cycle after the second key byte. A set request made at any other time is dropped. Clearing the enable needs no key, so software can lock the timer registers again at once after its update.

The block has three parts. A key matcher tracks progress through the two-byte key. A window timer holds the unlock window open for a parameterised number of cycles; the default of one gives a single-cycle window. An enable register takes the set and clear requests. A status output shows when the window is open.

Top module: `keyed_wren_guard`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `wren_o` is 0 and `window_open_o` is 0. Any key progress is discarded.
- R2: A key write of 0x55 with no progress held, followed by a key write of 0xAA, raises `window_open_o` in the cycle after the 0xAA write. It stays high for WINDOW_CYC cycles (default 1).
- R3: A control write with `ctl_wren_val`=1 in a cycle where `window_open_o` is 1 makes `wren_o` 1 from the next cycle. The window closes at the same edge.
- R4: A control write with `ctl_wren_val`=1 while `window_open_o` is 0 leaves `wren_o` unchanged.
- R5: A control write with `ctl_wren_val`=0 makes `wren_o` 0 from the next cycle, whatever the key state.
- R6: After 0x55, a key write of any value other than 0xAA discards progress. This includes a second 0x55. A 0xAA that follows it does not open the window.
- R7: If no set request arrives while the window is open, the window closes on its own. A later set request is ignored.
- R8: A key write while the window is open closes it at the next edge. If that write is 0x55, it starts a new sequence.
- R9: If a set request and a key write arrive in the same open-window cycle, the set is taken.
- R10: Cycles with no key write between 0x55 and 0xAA do not disturb the progress held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| key_wr | input | 1 | Write strobe of the key register |
| key_data | input | DATA_W | Byte written to the key register |
| ctl_wr | input | 1 | Write strobe of the control register |
| ctl_wren_val | input | 1 | Value written to the enable bit |
| wren_o | output | 1 | Write-enable level gating timer-register writes |
| window_open_o | output | 1 | High while a set request would be accepted |

## Verification
Directed sequences cover several cases: the clean key followed by an immediate set; a set one cycle too late; a wrong or repeated second byte; idle gaps between the key bytes; and a key write colliding with the window. Each of these separates a correct window from one that is too long, one that never closes, or one that opens on the wrong byte order. A clear with no key, and a set with no key, separate the free clear path from the guarded set path. A long run of random key bytes, biased towards 0x55 and 0xAA, mixed with random set and clear requests, is compared cycle by cycle against a bench reference model. This catches ordering slips that the directed cases miss.

// File: rtl/keyed_wren_pkg.sv
package keyed_wren_pkg;
   localparam int unsigned DEF_DATA_W = 8;
   localparam logic [7:0]  DEF_KEY_A  = 8'h55;
   localparam logic [7:0]  DEF_KEY_B  = 8'hAA;

   typedef enum logic [1:0] {
      ENA_HOLD  = 2'd0,
      ENA_SET   = 2'd1,
      ENA_CLEAR = 2'd2
   } ena_op_e;
endpackage

// File: rtl/keyed_wren_matcher.sv
module keyed_wren_matcher #(
   parameter int unsigned DATA_W = 8,
   parameter logic [DATA_W-1:0] KEY_A = 8'h55,
   parameter logic [DATA_W-1:0] KEY_B = 8'hAA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_wr,
   input  logic [DATA_W-1:0] key_data,
   output logic              armed_o,
   output logic              seq_done_o
);
   logic armed_q;
   logic armed_d;
   logic hit_a;
   logic hit_b;

   if (KEY_A == KEY_B) begin : g_bad_keys
      $error("keyed_wren_matcher: the two key bytes must differ");
   end

   assign hit_a = (key_data == KEY_A);
   assign hit_b = (key_data == KEY_B);

   // Progress advances only on key writes; any unexpected byte drops it.
   always_comb begin
      armed_d = armed_q;
      if (key_wr) begin
         armed_d = !armed_q && hit_a;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= armed_d;
   end

   assign armed_o    = armed_q;
   assign seq_done_o = key_wr && armed_q && hit_b;

   // R6: a wrong byte after the first key leaves no progress
   a_r6_wrong_byte_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && key_wr && !hit_b) |=> !armed_q);
   // R10: idle cycles keep progress
   a_r10_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && !key_wr) |=> armed_q);
endmodule

// File: rtl/keyed_wren_window.sv
module keyed_wren_window #(
   parameter int unsigned WINDOW_CYC = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic open_req,
   input  logic cancel,
   output logic open_o
);
   if (WINDOW_CYC < 1) begin : g_bad_window
      $error("keyed_wren_window: WINDOW_CYC must be at least 1");
   end

   if (WINDOW_CYC == 1) begin : g_single
      logic open_q;
      always_ff @(posedge clk) begin
         if (!rst_n) open_q <= 1'b0;
         else        open_q <= open_req;
      end
      assign open_o = open_q;
   end else begin : g_count
      localparam int unsigned CNT_W = $clog2(WINDOW_CYC + 1);
      localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WINDOW_CYC);
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)             cnt_q <= '0;
         else if (open_req)      cnt_q <= CNT_LOAD;
         else if (cancel)        cnt_q <= '0;
         else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end
      assign open_o = (cnt_q != '0);

      // R7: the window never holds more than its length
      a_r7_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= CNT_LOAD);
   end
endmodule

// File: rtl/keyed_wren_enable.sv
module keyed_wren_enable
   import keyed_wren_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_wr,
   input  logic ctl_val,
   input  logic window_open,
   output logic set_take_o,
   output logic wren_o
);
   ena_op_e op;
   logic    wren_q;

   always_comb begin
      op = ENA_HOLD;
      if (ctl_wr && !ctl_val)                  op = ENA_CLEAR;
      else if (ctl_wr && ctl_val && window_open) op = ENA_SET;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wren_q <= 1'b0;
      end else begin
         unique case (op)
            ENA_SET:   wren_q <= 1'b1;
            ENA_CLEAR: wren_q <= 1'b0;
            default:   wren_q <= wren_q;
         endcase
      end
   end

   assign set_take_o = (op == ENA_SET);
   assign wren_o     = wren_q;

   // R5: a clear request always takes effect
   a_r5_clear_free: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !ctl_val) |=> !wren_q);
   // R4: a set with the window shut changes nothing
   a_r4_closed_set_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!window_open && ctl_wr && ctl_val) |=> $stable(wren_q));
endmodule

// File: rtl/keyed_wren_guard.sv
module keyed_wren_guard
   import keyed_wren_pkg::*;
#(
   parameter int unsigned DATA_W     = DEF_DATA_W,
   parameter logic [DATA_W-1:0] KEY_A = DATA_W'(DEF_KEY_A),
   parameter logic [DATA_W-1:0] KEY_B = DATA_W'(DEF_KEY_B),
   parameter int unsigned WINDOW_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_wr,
   input  logic [DATA_W-1:0] key_data,
   input  logic              ctl_wr,
   input  logic              ctl_wren_val,
   output logic              wren_o,
   output logic              window_open_o
);
   logic armed;
   logic seq_done;
   logic win_open;
   logic set_take;
   logic win_cancel;

   if (DATA_W < 2) begin : g_bad_width
      $error("keyed_wren_guard: DATA_W must be at least 2");
   end

   keyed_wren_matcher #(
      .DATA_W (DATA_W),
      .KEY_A  (KEY_A),
      .KEY_B  (KEY_B)
   ) matcher_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .key_wr     (key_wr),
      .key_data   (key_data),
      .armed_o    (armed),
      .seq_done_o (seq_done)
   );

   assign win_cancel = key_wr || set_take;

   keyed_wren_window #(
      .WINDOW_CYC (WINDOW_CYC)
   ) window_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_req (seq_done),
      .cancel   (win_cancel),
      .open_o   (win_open)
   );

   keyed_wren_enable enable_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl_wr      (ctl_wr),
      .ctl_val     (ctl_wren_val),
      .window_open (win_open),
      .set_take_o  (set_take),
      .wren_o      (wren_o)
   );

   assign window_open_o = win_open;

   // R3: the enable rises only after a set request inside the window
   a_r3_rise_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wren_o) |-> $past(window_open_o && ctl_wr && ctl_wren_val));
   // R2: the window opens only right after the second key byte
   a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(window_open_o) |-> $past(key_wr && key_data == KEY_B && armed));
   // R8: a key write inside the window shuts it
   a_r8_key_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (window_open_o && key_wr) |=> !window_open_o);
   // R3: an accepted set shuts the window
   a_r3_set_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (window_open_o && ctl_wr && ctl_wren_val) |=> (!window_open_o && wren_o));
endmodule

// File: tb/keyed_wren_guard_tb_top.sv
module keyed_wren_guard_tb_top;
   localparam int unsigned W = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       key_wr = 1'b0;
   logic [7:0] key_data = 8'h00;
   logic       ctl_wr = 1'b0;
   logic       ctl_wren_val = 1'b0;
   logic       wren_o;
   logic       window_open_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // bench reference state
   bit m_armed = 1'b0;
   int m_cnt = 0;
   bit m_wren = 1'b0;

   always #2.5 clk = ~clk;

   keyed_wren_guard #(.WINDOW_CYC(W)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .key_wr        (key_wr),
      .key_data      (key_data),
      .ctl_wr        (ctl_wr),
      .ctl_wren_val  (ctl_wren_val),
      .wren_o        (wren_o),
      .window_open_o (window_open_o)
   );

   function automatic bit exp_wren(bit cw, bit cv, int cnt, bit wr);
      if (cw && cv && cnt != 0) return 1'b1;
      if (cw && !cv)            return 1'b0;
      return wr;
   endfunction

   function automatic int exp_cnt(bit kw, bit [7:0] kd, bit cw, bit cv, bit armed, int cnt);
      if (kw && armed && kd == 8'hAA) return W;
      if (kw || (cw && cv && cnt != 0)) return 0;
      return (cnt != 0) ? cnt - 1 : 0;
   endfunction

   task automatic chk(input string req, input bit act, input bit exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input bit kw, input bit [7:0] kd, input bit cw, input bit cv);
      bit nw;
      int nc;
      bit na;
      @(negedge clk);
      key_wr = kw; key_data = kd; ctl_wr = cw; ctl_wren_val = cv;
      @(posedge clk);
      if (!rst_n) begin
         m_armed = 1'b0; m_cnt = 0; m_wren = 1'b0;
      end else begin
         nw = exp_wren(cw, cv, m_cnt, m_wren);
         nc = exp_cnt(kw, kd, cw, cv, m_armed, m_cnt);
         na = kw ? (!m_armed && kd == 8'h55) : m_armed;
         m_wren = nw; m_cnt = nc; m_armed = na;
      end
      #1;
   endtask

   task automatic idle(); cyc(1'b0, 8'h00, 1'b0, 1'b0); endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20517));
      // R1 reset state
      idle(); idle();
      chk("R1 wren in reset", wren_o, 1'b0);
      chk("R1 window in reset", window_open_o, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      idle();
      chk("R1 wren after reset", wren_o, 1'b0);
      chk("R1 window after reset", window_open_o, 1'b0);

      // R4 set without key
      cyc(1'b0, 8'h00, 1'b1, 1'b1);
      chk("R4 set without key", wren_o, 1'b0);

      // R2 then R3 clean unlock
      cyc(1'b1, 8'h55, 1'b0, 1'b0);
      chk("R2 no window after first byte", window_open_o, 1'b0);
      cyc(1'b1, 8'hAA, 1'b0, 1'b0);
      chk("R2 window opens", window_open_o, 1'b1);
      cyc(1'b0, 8'h00, 1'b1, 1'b1);
      chk("R3 wren set", wren_o, 1'b1);
      chk("R3 window closed after set", window_open_o, 1'b0);

      // R5 clear without key
      cyc(1'b0, 8'h00, 1'b1, 1'b0);
      chk("R5 clear", wren_o, 1'b0);

      // R7 late set ignored
      cyc(1'b1, 8'h55, 1'b0, 1'b0);
      cyc(1'b1, 8'hAA, 1'b0, 1'b0);
      idle();
      chk("R7 window expired", window_open_o, 1'b0);
      cyc(1'b0, 8'h00, 1'b1, 1'b1);
      chk("R7 late set ignored", wren_o, 1'b0);

      // R6 repeated first byte
      cyc(1'b1, 8'h55, 1'b0, 1'b0);
      cyc(1'b1, 8'h55, 1'b0, 1'b0);
      cyc(1'b1, 8'hAA, 1'b0, 1'b0);
      chk("R6 55 55 AA no window", window_open_o, 1'b0);
      cyc(1'b0, 8'h00, 1'b1, 1'b1);
      chk("R6 set refused", wren_o, 1'b0);
      // R6 wrong second byte
      cyc(1'b1, 8'h55, 1'b0, 1'b0);
      cyc(1'b1, 8'h12, 1'b0, 1'b0);
      cyc(1'b1, 8'hAA, 1'b0, 1'b0);
      chk("R6 55 12 AA no window", window_open_o, 1'b0);

      // R10 idle gaps between bytes
      cyc(1'b1, 8'h55, 1'b0, 1'b0);
      idle(); idle(); idle();
      cyc(1'b1, 8'hAA, 1'b0, 1'b0);
      chk("R10 window after gaps", window_open_o, 1'b1);
      // R8 key write inside window closes it and 55 restarts
      cyc(1'b1, 8'h55, 1'b0, 1'b0);
      chk("R8 key write closes window", window_open_o, 1'b0);
      cyc(1'b1, 8'hAA, 1'b0, 1'b0);
      chk("R8 restart opens window", window_open_o, 1'b1);
      // R9 set and key write together
      cyc(1'b1, 8'h33, 1'b1, 1'b1);
      chk("R9 set wins", wren_o, 1'b1);
      chk("R9 window closed", window_open_o, 1'b0);
      cyc(1'b0, 8'h00, 1'b1, 1'b0);
      chk("R5 clear again", wren_o, 1'b0);

      // random run against the reference model
      for (int i = 0; i < 4000; i++) begin
         bit kw = ($urandom % 3) != 0;
         int sel = $urandom % 8;
         bit [7:0] kd = (sel < 3) ? 8'h55 : (sel < 6) ? 8'hAA : 8'($urandom);
         bit cw = ($urandom % 3) == 0;
         bit cv = ($urandom % 4) != 0;
         cyc(kw, kd, cw, cv);
         chk("R2 R3 R4 R5 R6 R7 R8 R9 random wren", wren_o, m_wren);
         chk("R2 R7 R8 random window", window_open_o, m_cnt != 0);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule